// File: doc/BRIEF.md
# Serial Configuration Chain Shift Engine

This block lets software drive long serial configuration chains, one per lane group, through two registers. A configuration register holds a power-of-two clock divider exponent, a return-path selector that picks which group's chain output is fed back, and one bypass bit per group. A data/command register holds a 32-bit shift window, a bit count, a one-hot group select and three self-clearing command bits: shift, update and capture.

A shift moves 1 to 32 bits through the selected chain. Window bit 0 leaves first. Each bit returned from the chain enters the window at its most significant end, so after an N-bit shift the returned bits are left-justified in the window. Update and capture each issue a single strobe one serial-clock period long. Update commits the shifted contents to every lane of the group. Capture reloads the chain from the lanes. Software polls the command bits to see when an operation has finished. Chains longer than 32 bits are handled by software issuing repeated shifts.

The sequencer has five states: IDLE, SHIFT_LO (serial clock low, data presented), SHIFT_HI (serial clock high), UPDATE and CAPTURE. The transitions are:
- GO_SHIFT: IDLE to SHIFT_LO.
- GO_UPDATE: IDLE to UPDATE.
- GO_CAPTURE: IDLE to CAPTURE.
- RISE: SHIFT_LO to SHIFT_HI, after half a serial period, sampling the return bit.
- FALL_NEXT: SHIFT_HI to SHIFT_LO, after half a period, when bits remain; the window advances.
- FALL_LAST: SHIFT_HI to IDLE, on the final bit; the window advances.
- STROBE_END: UPDATE or CAPTURE to IDLE, after one full period.

Top module: `chain_shift_engine`

## Requirements
- R1: After reset both registers read as zero, every chain output is low and the divider exponent is 0, so the serial period is 4 system clocks.
- R2: The serial clock period is 2^(k+2) system clocks, where k is the exponent in config bits [3:0]. Each period has a low half followed by a high half, and exactly N rising edges occur for an N-bit shift.
- R3: Data register bits [36:32] hold N-1. Writing data bit 40 shifts N bits. Bit 40 reads back as 1 for exactly N×2^(k+2) system clocks after the accepting edge and then clears.
- R4: Window bit 0 is presented first, then bit 1, and so on. The data output changes only when the serial clock falls and holds steady while the clock is high.
- R5: The chain bit is sampled at each rising serial edge and enters window bit 31 as the window moves toward bit 0. After N bits, window bits [31:32-N] hold the returned bits (first-returned lowest) and bits [31-N:0] hold the old window shifted right by N.
- R6: Writing data bit 41 raises the update strobe of each enabled selected group for exactly one serial period. Bit 41 reads 1 for that period and then clears.
- R7: Writing data bit 42 raises the capture strobe of each enabled selected group for exactly one serial period. Bit 42 reads 1 for that period and then clears.
- R8: When several command bits are written at once, only one runs. Shift wins over update, which wins over capture, and only the winning bit reads back as set.
- R9: A data-register write is ignored while any command bit is set. This includes a write sampled at the very edge on which the operation finishes.
- R10: Data bits [51:48] select groups one-hot. A group whose bypass bit (config bits [19:16]) is set sees no clock, data or strobe activity. The return bit always comes from the group named by config bits [9:8], whether or not that group is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration register, 1 = data/command register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Live read data of the register at reg_addr |
| chain_clk | output | NUM_GRP | Serial clock per group |
| chain_din | output | NUM_GRP | Serial data into each chain |
| chain_upd | output | NUM_GRP | Update strobe per group |
| chain_cap | output | NUM_GRP | Capture strobe per group |
| chain_dout | input | NUM_GRP | Serial data returned from each chain |

## Verification
Two events can land on the same system-clock edge: the sequencer finishing an operation, which clears its command bit, and software writing a new command. The bench provokes this by timing a data write so that it is sampled on the exact completion edge of a shift. It then reads back the count and select fields and the command bits, and watches the chain outputs for several more cycles. The write counts as correctly ignored if the fields still hold the old values, no command bit is set, and no new serial activity appears. A second case writes during the middle of a shift and is judged the same way.

// File: rtl/chain_pkg.sv
package chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SHIFT_LO = 3'd1,
        ST_SHIFT_HI = 3'd2,
        ST_UPDATE   = 3'd3,
        ST_CAPTURE  = 3'd4
    } seq_state_e;

    localparam int REG_W         = 64;
    // configuration register field positions
    localparam int CFG_DIV_LSB   = 0;
    localparam int CFG_RSEL_LSB  = 8;
    localparam int CFG_BYP_LSB   = 16;
    // data / command register field positions
    localparam int DAT_WIN_LSB   = 0;
    localparam int DAT_CNT_LSB   = 32;
    localparam int DAT_SHIFT_BIT = 40;
    localparam int DAT_UPD_BIT   = 41;
    localparam int DAT_CAP_BIT   = 42;
    localparam int DAT_SEL_LSB   = 48;

endpackage

// File: rtl/chain_divider.sv
module chain_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_exp,
    output logic             half_end
);
    localparam int CNT_W = (1 << DIV_W) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   half_len;

    always_comb begin
        half_len = (CNT_W+1)'(1) << ({1'b0, div_exp} + (DIV_W+1)'(1));
        half_end = run && ({1'b0, cnt_q} == (half_len - (CNT_W+1)'(1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || half_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/chain_window.sv
module chain_window #(
    parameter int WIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIN_W-1:0] load_val,
    input  logic             shift,
    input  logic             in_bit,
    output logic [WIN_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {in_bit, q[WIN_W-1:1]};
    end
endmodule

// File: rtl/chain_seq.sv
module chain_seq
    import chain_pkg::*;
#(
    parameter int CNT_FW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_shift,
    input  logic              go_update,
    input  logic              go_capture,
    input  logic [CNT_FW-1:0] nbits_m1,
    input  logic              half_end,
    input  logic              chain_bit,
    output seq_state_e        state_q,
    output logic              step,
    output logic              cap_bit
);
    seq_state_e        state_nx;
    logic [CNT_FW-1:0] left_q;
    logic              second_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_shift)        state_nx = ST_SHIFT_LO;
                else if (go_update)  state_nx = ST_UPDATE;
                else if (go_capture) state_nx = ST_CAPTURE;
            end
            ST_SHIFT_LO: if (half_end) state_nx = ST_SHIFT_HI;
            ST_SHIFT_HI: begin
                if (half_end)
                    state_nx = (left_q == '0) ? ST_IDLE : ST_SHIFT_LO;
            end
            ST_UPDATE, ST_CAPTURE: begin
                if (half_end && second_q) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // output decode: window advances on the falling serial edge
    always_comb begin
        step = (state_q == ST_SHIFT_HI) && half_end;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q   <= '0;
            second_q <= 1'b0;
            cap_bit  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && go_shift)
                left_q <= nbits_m1;
            else if (step && left_q != '0)
                left_q <= left_q - CNT_FW'(1);

            if (state_q == ST_IDLE)
                second_q <= 1'b0;
            else if ((state_q == ST_UPDATE || state_q == ST_CAPTURE) && half_end)
                second_q <= ~second_q;

            if (state_q == ST_SHIFT_LO && half_end)
                cap_bit <= chain_bit;
        end
    end
endmodule

// File: rtl/chain_shift_engine.sv
module chain_shift_engine
    import chain_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int WIN_W   = 32,
    parameter int DIV_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [NUM_GRP-1:0] chain_clk,
    output logic [NUM_GRP-1:0] chain_din,
    output logic [NUM_GRP-1:0] chain_upd,
    output logic [NUM_GRP-1:0] chain_cap,
    input  logic [NUM_GRP-1:0] chain_dout
);
    localparam int SEL_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam int CNT_FW = $clog2(WIN_W);

    logic [DIV_W-1:0]   cfg_div;
    logic [SEL_W-1:0]   cfg_rsel;
    logic [NUM_GRP-1:0] cfg_bypass;
    logic [NUM_GRP-1:0] grp_sel;
    logic [CNT_FW-1:0]  nbits_m1;
    logic [WIN_W-1:0]   window;
    seq_state_e         state_q;
    logic               idle, dat_acc, go_shift, go_update, go_capture;
    logic               half_end, step, cap_bit, chain_bit;
    logic               in_shift;
    logic               unused_wbits;

    assign unused_wbits = ^reg_wdata;

    // configuration register: always writable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_div    <= '0;
            cfg_rsel   <= '0;
            cfg_bypass <= '0;
        end else if (reg_wr && !reg_addr) begin
            cfg_div    <= reg_wdata[CFG_DIV_LSB +: DIV_W];
            cfg_rsel   <= reg_wdata[CFG_RSEL_LSB +: SEL_W];
            cfg_bypass <= reg_wdata[CFG_BYP_LSB +: NUM_GRP];
        end
    end

    // command acceptance and priority
    always_comb begin
        idle       = (state_q == ST_IDLE);
        in_shift   = (state_q == ST_SHIFT_LO) || (state_q == ST_SHIFT_HI);
        dat_acc    = reg_wr && reg_addr && idle;
        go_shift   = dat_acc && reg_wdata[DAT_SHIFT_BIT];
        go_update  = dat_acc && !reg_wdata[DAT_SHIFT_BIT] && reg_wdata[DAT_UPD_BIT];
        go_capture = dat_acc && !reg_wdata[DAT_SHIFT_BIT] && !reg_wdata[DAT_UPD_BIT]
                     && reg_wdata[DAT_CAP_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_sel  <= '0;
            nbits_m1 <= '0;
        end else if (dat_acc) begin
            grp_sel  <= reg_wdata[DAT_SEL_LSB +: NUM_GRP];
            nbits_m1 <= reg_wdata[DAT_CNT_LSB +: CNT_FW];
        end
    end

    // return-path selector
    always_comb begin
        chain_bit = 1'b0;
        for (int g = 0; g < NUM_GRP; g++)
            if (cfg_rsel == SEL_W'(g)) chain_bit = chain_dout[g];
    end

    chain_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (!idle),
        .div_exp  (cfg_div),
        .half_end (half_end)
    );

    chain_seq #(.CNT_FW(CNT_FW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_shift   (go_shift),
        .go_update  (go_update),
        .go_capture (go_capture),
        .nbits_m1   (reg_wdata[DAT_CNT_LSB +: CNT_FW]),
        .half_end   (half_end),
        .chain_bit  (chain_bit),
        .state_q    (state_q),
        .step       (step),
        .cap_bit    (cap_bit)
    );

    chain_window #(.WIN_W(WIN_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dat_acc),
        .load_val (reg_wdata[DAT_WIN_LSB +: WIN_W]),
        .shift    (step),
        .in_bit   (cap_bit),
        .q        (window)
    );

    // per-group output gating
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic grp_en;
        assign grp_en       = grp_sel[g] && !cfg_bypass[g];
        assign chain_clk[g] = grp_en && (state_q == ST_SHIFT_HI);
        assign chain_din[g] = grp_en && in_shift && window[0];
        assign chain_upd[g] = grp_en && (state_q == ST_UPDATE);
        assign chain_cap[g] = grp_en && (state_q == ST_CAPTURE);
    end

    // live readback
    always_comb begin
        reg_rdata = '0;
        if (!reg_addr) begin
            reg_rdata[CFG_DIV_LSB +: DIV_W]    = cfg_div;
            reg_rdata[CFG_RSEL_LSB +: SEL_W]   = cfg_rsel;
            reg_rdata[CFG_BYP_LSB +: NUM_GRP]  = cfg_bypass;
        end else begin
            reg_rdata[DAT_WIN_LSB +: WIN_W]    = window;
            reg_rdata[DAT_CNT_LSB +: CNT_FW]   = nbits_m1;
            reg_rdata[DAT_SHIFT_BIT]           = in_shift;
            reg_rdata[DAT_UPD_BIT]             = (state_q == ST_UPDATE);
            reg_rdata[DAT_CAP_BIT]             = (state_q == ST_CAPTURE);
            reg_rdata[DAT_SEL_LSB +: NUM_GRP]  = grp_sel;
        end
    end
endmodule

// File: rtl/chain_shift_engine_chk.sv
module chain_shift_engine_chk
    import chain_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int CNT_FW  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input seq_state_e         state_q,
    input logic               reg_wr,
    input logic               reg_addr,
    input logic [NUM_GRP-1:0] grp_sel,
    input logic [CNT_FW-1:0]  nbits_m1,
    input logic [NUM_GRP-1:0] cfg_bypass,
    input logic [NUM_GRP-1:0] chain_clk,
    input logic [NUM_GRP-1:0] chain_din,
    input logic [NUM_GRP-1:0] chain_upd,
    input logic [NUM_GRP-1:0] chain_cap
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (chain_clk == '0 && chain_upd == '0 && chain_cap == '0));

    p_din_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|chain_clk) && $past(|chain_clk)) |-> $stable(chain_din));

    p_upd_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|chain_upd) |=> (|chain_upd));

    p_cap_min_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|chain_cap) |=> (|chain_cap));

    p_one_activity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|chain_clk, |chain_upd, |chain_cap}));

    p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && reg_wr && reg_addr) |=> ($stable(grp_sel) && $stable(nbits_m1)));

    p_bypass_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((chain_clk | chain_din | chain_upd | chain_cap) & cfg_bypass) == '0);
endmodule

bind chain_shift_engine chain_shift_engine_chk #(.NUM_GRP(NUM_GRP), .CNT_FW(CNT_FW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .grp_sel    (grp_sel),
    .nbits_m1   (nbits_m1),
    .cfg_bypass (cfg_bypass),
    .chain_clk  (chain_clk),
    .chain_din  (chain_din),
    .chain_upd  (chain_upd),
    .chain_cap  (chain_cap)
);

// File: tb/chain_shift_engine_tb_top.sv
module chain_shift_engine_tb_top;
    localparam int NG = 4;
    localparam int L  = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b1;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [NG-1:0] chain_clk, chain_din, chain_upd, chain_cap, chain_dout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    chain_shift_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chain_clk(chain_clk), .chain_din(chain_din), .chain_upd(chain_upd),
        .chain_cap(chain_cap), .chain_dout(chain_dout)
    );

    // chain environment model, sampled away from the active edge
    logic [L-1:0] chain_m [NG] = '{default: '0};
    logic [L-1:0] lanes_m [NG] = '{default: '0};
    logic [L-1:0] cap_pat [NG] = '{default: '0};
    logic [NG-1:0] prev_clk = '0, prev_upd = '0, prev_cap = '0;
    int rise_cnt [NG] = '{default: 0};
    int hi_cnt   [NG] = '{default: 0};
    int upd_rise [NG] = '{default: 0};
    int upd_hi   [NG] = '{default: 0};
    int cap_rise [NG] = '{default: 0};
    int cap_hi   [NG] = '{default: 0};

    for (genvar g = 0; g < NG; g++) begin : g_out
        assign chain_dout[g] = chain_m[g][L-1];
    end

    always @(negedge clk) begin
        for (int g = 0; g < NG; g++) begin
            if (chain_clk[g]) hi_cnt[g] <= hi_cnt[g] + 1;
            if (chain_upd[g]) upd_hi[g] <= upd_hi[g] + 1;
            if (chain_cap[g]) cap_hi[g] <= cap_hi[g] + 1;
            if (chain_clk[g] && !prev_clk[g]) begin
                rise_cnt[g] <= rise_cnt[g] + 1;
                chain_m[g]  <= {chain_m[g][L-2:0], chain_din[g]};
            end
            if (chain_upd[g] && !prev_upd[g]) begin
                upd_rise[g] <= upd_rise[g] + 1;
                lanes_m[g]  <= chain_m[g];
            end
            if (chain_cap[g] && !prev_cap[g]) begin
                cap_rise[g] <= cap_rise[g] + 1;
                chain_m[g]  <= cap_pat[g];
            end
        end
        prev_clk <= chain_clk;
        prev_upd <= chain_upd;
        prev_cap <= chain_cap;
    end

    // expected-value functions
    function automatic logic [63:0] cfg_word(int k, int rsel, logic [3:0] byp);
        logic [63:0] w = '0;
        w[3:0]   = 4'(k);
        w[9:8]   = 2'(rsel);
        w[19:16] = byp;
        return w;
    endfunction

    function automatic logic [63:0] dat_word(logic [31:0] win, int n, logic sh, logic up,
                                             logic cp, logic [3:0] sel);
        logic [63:0] w = '0;
        w[31:0]  = win;
        w[36:32] = 5'(n - 1);
        w[40]    = sh;
        w[41]    = up;
        w[42]    = cp;
        w[51:48] = sel;
        return w;
    endfunction

    function automatic logic [31:0] exp_window(logic [31:0] d, int n, logic [L-1:0] old,
                                               logic live, logic fixed_bit);
        logic [31:0] r = '0;
        for (int j = 0; j < 32; j++) begin
            if (j < 32 - n) r[j] = d[j + n];
            else            r[j] = live ? old[L-1-(j-(32-n))] : fixed_bit;
        end
        return r;
    endfunction

    function automatic logic [L-1:0] exp_chain(logic [L-1:0] old, logic [31:0] d, int n);
        logic [L-1:0] r = '0;
        for (int j = 0; j < L; j++) begin
            if (j < n) r[j] = d[n-1-j];
            else       r[j] = old[j-n];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [63:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b1;
        #1;
    endtask

    task automatic wait_busy(input int bit_i, output int cyc);
        cyc = 0;
        while (reg_rdata[bit_i] && cyc < 100000) begin
            cyc++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_shift(input int g, input int rsel, input logic [3:0] byp, input int k,
                            input int n, input logic [31:0] d);
        logic [L-1:0] old_g, old_r;
        int r0, h0, cyc, p;
        logic live;
        p = 1 << (k + 2);
        @(negedge clk); #1;
        old_g = chain_m[g]; old_r = chain_m[rsel];
        r0 = rise_cnt[g]; h0 = hi_cnt[g];
        live = !byp[g];
        wr(1'b0, cfg_word(k, rsel, byp));
        wr(1'b1, dat_word(d, n, 1'b1, 1'b0, 1'b0, 4'(1 << g)));
        wait_busy(40, cyc);
        chk(cyc == n * p, "R3 shift busy cycles", 64'(cyc), 64'(n * p));
        if (live) begin
            chk(rise_cnt[g] - r0 == n, "R2 serial rising edges", 64'(rise_cnt[g] - r0), 64'(n));
            chk(hi_cnt[g] - h0 == n * p / 2, "R2 serial high time", 64'(hi_cnt[g] - h0), 64'(n * p / 2));
            chk(chain_m[g] == exp_chain(old_g, d, n), "R4 bit order into chain",
                64'(chain_m[g]), 64'(exp_chain(old_g, d, n)));
        end else begin
            chk(rise_cnt[g] == r0, "R10 bypassed group clock quiet", 64'(rise_cnt[g]), 64'(r0));
            chk(chain_m[g] == old_g, "R10 bypassed chain untouched", 64'(chain_m[g]), 64'(old_g));
        end
        chk(reg_rdata[31:0] == exp_window(d, n, old_r, live && rsel == g, old_r[L-1]),
            "R5 returned window", 64'(reg_rdata[31:0]),
            64'(exp_window(d, n, old_r, live && rsel == g, old_r[L-1])));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog act=hung exp=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        int cyc, u0, c0, uh0, ch0;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        v = reg_rdata;
        chk(v == '0, "R1 data register reset", v, 64'h0);
        reg_addr = 1'b0; #1;
        chk(reg_rdata == '0, "R1 config register reset", reg_rdata, 64'h0);
        reg_addr = 1'b1; #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk({chain_clk, chain_din, chain_upd, chain_cap} == '0, "R1 outputs low",
            64'({chain_clk, chain_din, chain_upd, chain_cap}), 64'h0);
        // R1: default divider gives period 4 (shift without touching config)
        wr(1'b1, dat_word(32'h0000_0005, 3, 1'b1, 1'b0, 1'b0, 4'b0001));
        wait_busy(40, cyc);
        chk(cyc == 12, "R1 default period 4", 64'(cyc), 64'd12);

        // R7: capture loads chain, then read it back through a full shift
        cap_pat[2] = 48'h9C3A_5F01_E7B2;
        wr(1'b0, cfg_word(2, 2, 4'b0000));
        @(negedge clk); #1;
        c0 = cap_rise[2]; ch0 = cap_hi[2];
        wr(1'b1, dat_word('0, 1, 1'b0, 1'b0, 1'b1, 4'b0100));
        wait_busy(42, cyc);
        chk(cyc == 16, "R7 capture busy one period", 64'(cyc), 64'd16);
        chk(cap_hi[2] - ch0 == 16, "R7 capture strobe width", 64'(cap_hi[2] - ch0), 64'd16);
        chk(cap_rise[2] - c0 == 1, "R7 single capture strobe", 64'(cap_rise[2] - c0), 64'd1);
        chk(chain_m[2] == cap_pat[2], "R7 chain reloaded", 64'(chain_m[2]), 64'(cap_pat[2]));
        do_shift(2, 2, 4'b0000, 0, 32, 32'hDEAD_BEEF);

        // R6: update commits chain contents to lanes
        do_shift(1, 1, 4'b0000, 1, 20, 32'h000A_BCDE);
        @(negedge clk); #1;
        u0 = upd_rise[1]; uh0 = upd_hi[1];
        wr(1'b1, dat_word('0, 1, 1'b0, 1'b1, 1'b0, 4'b0010));
        wait_busy(41, cyc);
        chk(cyc == 8, "R6 update busy one period", 64'(cyc), 64'd8);
        chk(upd_hi[1] - uh0 == 8, "R6 update strobe width", 64'(upd_hi[1] - uh0), 64'd8);
        chk(lanes_m[1] == chain_m[1], "R6 lanes committed", 64'(lanes_m[1]), 64'(chain_m[1]));

        // R8: update and capture together -> update only
        u0 = upd_rise[1]; c0 = cap_rise[1];
        wr(1'b1, dat_word('0, 1, 1'b0, 1'b1, 1'b1, 4'b0010));
        v = reg_rdata;
        chk(v[42:41] == 2'b01, "R8 update wins over capture", 64'(v[42:41]), 64'd1);
        wait_busy(41, cyc);
        chk(upd_rise[1] - u0 == 1 && cap_rise[1] == c0, "R8 only update strobe",
            64'(cap_rise[1] - c0), 64'd0);
        // R8: shift and update together -> shift only
        u0 = upd_rise[1];
        wr(1'b1, dat_word(32'h1, 2, 1'b1, 1'b1, 1'b0, 4'b0010));
        v = reg_rdata;
        chk(v[42:40] == 3'b001, "R8 shift wins over update", 64'(v[42:40]), 64'd1);
        wait_busy(40, cyc);
        chk(upd_rise[1] == u0, "R8 no update strobe", 64'(upd_rise[1] - u0), 64'd0);

        // R9: write in the middle of a shift
        wr(1'b0, cfg_word(1, 0, 4'b0000));
        wr(1'b1, dat_word(32'h55, 8, 1'b1, 1'b0, 1'b0, 4'b0001));
        repeat (10) @(negedge clk);
        wr(1'b1, dat_word(32'hFFFF, 3, 1'b1, 1'b0, 1'b0, 4'b1000));
        wait_busy(40, cyc);
        v = reg_rdata;
        chk(v[36:32] == 5'd7 && v[51:48] == 4'b0001, "R9 mid-shift write ignored",
            {v[51:48], 27'h0, v[36:32]}, 64'h1_0000_0007);
        // R9: write sampled on the completion edge
        wr(1'b0, cfg_word(0, 0, 4'b0000));
        wr(1'b1, dat_word(32'h9, 4, 1'b1, 1'b0, 1'b0, 4'b0001));
        repeat (15) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = dat_word(32'h3, 2, 1'b1, 1'b0, 1'b0, 4'b1000);
        @(negedge clk);
        reg_wr = 1'b0; #1;
        v = reg_rdata;
        chk(v[42:40] == 3'b000 && v[36:32] == 5'd3 && v[51:48] == 4'b0001,
            "R9 completion-edge write ignored", v[63:32], 64'h0001_0003);
        c0 = rise_cnt[3];
        repeat (6) @(negedge clk);
        #1;
        chk(rise_cnt[3] == c0 && reg_rdata[42:40] == 3'b000, "R9 no new operation started",
            64'(rise_cnt[3] - c0), 64'd0);

        // R10: bypassed target, and return path from an unselected group
        do_shift(0, 0, 4'b0001, 0, 10, 32'h0000_03A5);
        chain_m[3][L-1] = 1'b1;
        do_shift(1, 3, 4'b0000, 0, 12, 32'h0000_0F0F);

        // random sweep: R2 R3 R4 R5
        for (int it = 0; it < 16; it++) begin
            int g, n, k;
            logic [31:0] d;
            g = int'($urandom % 4);
            n = 1 + int'($urandom % 32);
            k = int'($urandom % 3);
            d = $urandom;
            do_shift(g, g, 4'b0000, k, n, d);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule